// File: doc/BRIEF.md
# Dual Circular-Buffer Address Stepper

The block keeps two 9-bit register addresses, a write-side pointer and a read-side pointer, for walking circular delay lines in filter loops. Each pointer has its own wrap-size selector `k` (0 to 8). A step changes only the low field, bits [k:0], and leaves bits [8:k+1] alone. The result is a ring of 2^(k+1) entries whose base is whatever the upper bits hold. No bound register and no comparison are involved, because the wrap comes from masking alone.

A loop loads both pointers once and then steps them on each iteration. The outputs are registered. In a cycle that requests a step, the outputs still show the current address, and the advanced address appears one clock later.

Top module: `ring_addr_stepper`

## Requirements
- R1: When synchronous reset `rst` is high at a clock edge, both address outputs become 0.
- R2: When `load` is high at a clock edge, `wr_addr` takes `wr_load_val` and `rd_addr` takes `rd_load_val`, whatever the step inputs are.
- R3: An increment step (`*_step`=1, `*_dec`=0) adds 1 modulo 2^(k+1) to bits [k:0] of that pointer, where k is `*_wrap_sel`.
- R4: A decrement step (`*_step`=1, `*_dec`=1) subtracts 1 modulo 2^(k+1) from bits [k:0] of that pointer.
- R5: A step never changes bits [8:k+1]. An increment from all-ones in [k:0] gives zeros there, and a decrement from zero gives all-ones, with no carry or borrow into bit k+1.
- R6: With `*_wrap_sel`=8 the whole 9-bit pointer wraps (511+1 gives 0, 0-1 gives 511).
- R7: The two pointers step independently, each with its own enable, direction and wrap size.
- R8: A pointer whose step input is low, with `load` low, keeps its value.
- R9: The output changes on the clock edge after the one that samples the step. During the stepping cycle the output shows the address before the step.
- R10: A `*_wrap_sel` value above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load both pointers; takes priority over stepping |
| wr_load_val | input | 9 | Load value for the write pointer |
| rd_load_val | input | 9 | Load value for the read pointer |
| wr_wrap_sel | input | 4 | Write pointer wrap selector k (ring size 2^(k+1)) |
| rd_wrap_sel | input | 4 | Read pointer wrap selector k |
| wr_step | input | 1 | Step the write pointer |
| rd_step | input | 1 | Step the read pointer |
| wr_dec | input | 1 | Write pointer direction: 1 decrement, 0 increment |
| rd_dec | input | 1 | Read pointer direction: 1 decrement, 0 increment |
| wr_addr | output | 9 | Current write pointer |
| rd_addr | output | 9 | Current read pointer |

## Verification
The bench aims at the ring edges:
- An increment from all-ones in the low field and a decrement from zero. A design that let the carry or borrow out would corrupt the base bits.
- k=0, where the ring has two entries, and k=8, where the whole field wraps. An off-by-one in the mask would give a ring of the wrong size.
- Load and step in the same cycle. A design that got the priority wrong would show the loaded value plus or minus one.
- Opposite directions with different wrap sizes on the two pointers, to expose any shared control.
- Out-of-range selectors, which must behave as k=8.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;
  parameter int ADDR_W = 9;
  parameter int SEL_W  = 4;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEL_W-1:0]  sel_t;
endpackage

// File: rtl/ring_mask_gen.sv
module ring_mask_gen
  import ring_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic [SW-1:0] sel,
  output logic [AW-1:0] mask
);
  localparam int MAXK = AW - 1;
  logic [SW-1:0] sel_c;
  always_comb begin
    sel_c = (int'(sel) > MAXK) ? SW'(MAXK) : sel;
  end
  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign mask[i] = (i <= int'(sel_c));
  end
endmodule

// File: rtl/ring_ptr.sv
module ring_ptr
  import ring_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [SW-1:0] wrap_sel,
  input  logic          step,
  input  logic          dec,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] mask, stepped, nxt;

  ring_mask_gen #(.AW(AW), .SW(SW)) u_mask (.sel(wrap_sel), .mask(mask));

  always_comb begin
    stepped = dec ? (addr - AW'(1)) : (addr + AW'(1));
    nxt = (stepped & mask) | (addr & ~mask);
  end

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= nxt;
  end

  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> ((addr & ~$past(mask)) == ($past(addr) & ~$past(mask))));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(addr));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(load_val)));
  // R3
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step && !dec && ((addr & mask) == mask)) |=> ((addr & $past(mask)) == '0));
  // R4
  dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step && dec && ((addr & mask) == '0)) |=> ((addr & $past(mask)) == $past(mask)));
endmodule

// File: rtl/ring_addr_stepper.sv
module ring_addr_stepper
  import ring_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] wr_load_val,
  input  logic [AW-1:0] rd_load_val,
  input  logic [SW-1:0] wr_wrap_sel,
  input  logic [SW-1:0] rd_wrap_sel,
  input  logic          wr_step,
  input  logic          rd_step,
  input  logic          wr_dec,
  input  logic          rd_dec,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  ring_ptr #(.AW(AW), .SW(SW)) u_wr (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_load_val),
    .wrap_sel(wr_wrap_sel), .step(wr_step), .dec(wr_dec), .addr(wr_addr));

  ring_ptr #(.AW(AW), .SW(SW)) u_rd (
    .clk(clk), .rst(rst), .load(load), .load_val(rd_load_val),
    .wrap_sel(rd_wrap_sel), .step(rd_step), .dec(rd_dec), .addr(rd_addr));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (wr_addr == '0 && rd_addr == '0));
  // R7
  indep_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !rd_step && wr_step) |=> $stable(rd_addr));
endmodule

// File: tb/tb_ring_addr_stepper.sv
`timescale 1ns/1ps
module tb_ring_addr_stepper;
  logic clk = 0, rst = 1, load = 0;
  logic [8:0] wr_load_val = 0, rd_load_val = 0;
  logic [3:0] wr_wrap_sel = 0, rd_wrap_sel = 0;
  logic wr_step = 0, rd_step = 0, wr_dec = 0, rd_dec = 0;
  logic [8:0] wr_addr, rd_addr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ring_addr_stepper dut (.*);

  function automatic logic [8:0] model(input logic [8:0] a, input int k, input bit d);
    logic [8:0] m, s;
    if (k > 8) k = 8;
    m = 9'((1 << (k + 1)) - 1);
    s = d ? a - 9'd1 : a + 9'd1;
    return (s & m) | (a & ~m);
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #5; endtask

  task automatic do_load(input logic [8:0] w, input logic [8:0] r);
    load = 1; wr_load_val = w; rd_load_val = r; tick(); load = 0;
  endtask

  task automatic t_reset;
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 wr", wr_addr, 0); chk("R1 rd", rd_addr, 0);
  endtask

  task automatic t_load_priority;
    wr_step = 1; rd_step = 1; wr_wrap_sel = 3; rd_wrap_sel = 3;
    do_load(9'd77, 9'd200);
    chk("R2 wr", wr_addr, 77); chk("R2 rd", rd_addr, 200);
    wr_step = 0; rd_step = 0;
  endtask

  task automatic t_inc_wrap;
    do_load(9'b101_110_101, 0);
    wr_wrap_sel = 2; wr_dec = 0; wr_step = 1;
    tick(); chk("R3 inc", wr_addr, 9'b101_110_110);
    tick(); chk("R3 inc", wr_addr, 9'b101_110_111);
    tick(); chk("R5 inc wrap", wr_addr, 9'b101_110_000);
    wr_step = 0;
  endtask

  task automatic t_dec_wrap;
    do_load(0, 9'b011_010_001);
    rd_wrap_sel = 1; rd_dec = 1; rd_step = 1;
    tick(); chk("R4 dec", rd_addr, 9'b011_010_000);
    tick(); chk("R5 dec wrap", rd_addr, 9'b011_010_011);
    rd_step = 0; rd_dec = 0;
  endtask

  task automatic t_k0;
    do_load(9'd300, 0); wr_wrap_sel = 0; wr_step = 1;
    tick(); chk("R5 k0", wr_addr, 301);
    tick(); chk("R5 k0 wrap", wr_addr, 300);
    wr_step = 0;
  endtask

  task automatic t_full;
    do_load(9'd511, 9'd0);
    wr_wrap_sel = 8; rd_wrap_sel = 8; wr_dec = 0; rd_dec = 1; wr_step = 1; rd_step = 1;
    tick(); chk("R6 wr", wr_addr, 0); chk("R6 rd", rd_addr, 511);
    wr_step = 0; rd_step = 0; rd_dec = 0;
  endtask

  task automatic t_indep;
    logic [8:0] ew, er;
    do_load(9'd40, 9'd129);
    wr_wrap_sel = 4; rd_wrap_sel = 2; wr_dec = 0; rd_dec = 1;
    ew = 40; er = 129;
    for (int i = 0; i < 20; i++) begin
      wr_step = 1; rd_step = (i % 3) != 0;
      tick();
      ew = model(ew, 4, 0);
      if ((i % 3) != 0) er = model(er, 2, 1);
      chk("R7 wr", wr_addr, ew); chk("R7 rd", rd_addr, er);
    end
    wr_step = 0; rd_step = 0; rd_dec = 0;
  endtask

  task automatic t_hold;
    do_load(9'd55, 9'd66);
    tick(); tick();
    chk("R8 wr", wr_addr, 55); chk("R8 rd", rd_addr, 66);
  endtask

  task automatic t_timing;
    do_load(9'd10, 0);
    wr_wrap_sel = 5;
    @(negedge clk); wr_step = 1;
    @(posedge clk); #1;
    wr_step = 0;
    @(negedge clk); chk("R9 after", wr_addr, 11);
    @(negedge clk); wr_step = 1; #1;
    chk("R9 during", wr_addr, 11);
    @(posedge clk); #1; wr_step = 0;
    @(negedge clk); chk("R9 next", wr_addr, 12);
  endtask

  task automatic t_oversel;
    do_load(9'd511, 9'd0);
    wr_wrap_sel = 4'd15; rd_wrap_sel = 4'd12; rd_dec = 1; wr_step = 1; rd_step = 1;
    tick(); chk("R10 wr", wr_addr, 0); chk("R10 rd", rd_addr, 511);
    wr_step = 0; rd_step = 0; rd_dec = 0;
  endtask

  initial begin
    #5;
    t_reset();
    t_load_priority();
    t_inc_wrap();
    t_dec_wrap();
    t_k0();
    t_full();
    t_indep();
    t_hold();
    t_timing();
    t_oversel();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule